// File: doc/BRIEF.md
# Carry-Save Montgomery Multiplier with Iteration Skipping

This block computes the Montgomery product A·B·2^-K mod N for a K-bit odd modulus N. It runs the radix-2 Montgomery recurrence one multiplier bit per iteration. The running sum is held as a pair of carry-save words, so each iteration costs a single row of full adders and no carry chain. A four-way operand select feeds that row with 0, B, N or B+N. B+N is formed once, when the operands are accepted.

The halving step of each iteration is not applied where the sum is produced. The unshifted pair is registered, and the shift happens as the pair is read in the next cycle. Reading the pair also tells the control whether the next iteration has anything to add. That iteration is empty when its multiplier bit is zero and bit 1 of both carry-save words is zero. In that case it reduces to an exact divide by two. It is folded into the shift, and the cycle performs the iteration after it. A zero detector ends the loop early once the accumulator and all remaining multiplier bits are zero.

At the end, one carry-propagate addition joins the pair, and N is subtracted once if needed. Operands enter through a valid/ready handshake that is ready only while the block is idle. The result leaves through a valid/ready handshake. Under back-pressure, out_valid and the result are held until the sink takes the result.

Top module: `msm_montmul`

## Requirements
- R1: With N odd, B < N and any K-bit A, the accepted result equals A·B·2^-K mod N.
- R2: The result is fully reduced, that is, strictly less than N.
- R3: in_ready is high only when no operation is in progress. An operand transfer happens on a clock edge where in_valid and in_ready are both high. in_valid and operand values presented while busy have no effect on the result being computed.
- R4: out_valid stays high and out_res stays stable until a clock edge where out_ready is high. After that edge the block is idle, with out_valid low and in_ready high.
- R5: When every bit of A is one, no iteration can be skipped, and out_valid rises exactly K+1 clock edges after the accepting edge.
- R6: out_valid rises no later than K+1 edges after the accepting edge. When A and B are both nonzero and K is even, it rises no earlier than K/2+1 edges after that edge.
- R7: If the accumulator and all remaining multiplier bits are zero, the loop ends at once. With A = 0, out_valid rises 2 edges after acceptance and the result is 0. With A = 1 and B = 0, it rises 3 edges after acceptance and the result is 0.
- R8: An iteration whose multiplier bit is zero, and whose incoming carry-save words both have bit 1 clear, is merged into the cycle before it. With only bit K-1 of A set and K even, out_valid rises K/2+1 edges after acceptance.
- R9: After reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands presented |
| in_ready | output | 1 | Block idle, operands will be taken |
| in_a | input | K | Multiplier A |
| in_b | input | K | Multiplicand B, must be below N |
| in_n | input | K | Odd modulus N |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Sink takes the result |
| out_res | output | K | A·B·2^-K mod N |

## Verification
Latency depends on the bit pattern of A, so each result is due somewhere between K/2+1 and K+1 edges after the accepting edge. The only exception is the early exit of the zero detector. The bench counts rising edges from the accepting edge. It samples out_valid at each falling edge, and checks that the count at which out_valid first appears falls inside that window. For the directed cases the count must equal an exact value: K+1 for an all-ones A, K/2+1 for a lone top bit, and 2 or 3 for the zero-detector cases. The result is read at the same falling edge, compared with a modular-halving reference, and then re-read while out_ready is held low to confirm that it is held.

// File: rtl/msm_pkg.sv
package msm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_OUT  = 2'd3
  } msm_state_e;
endpackage

// File: rtl/msm_opnd_mux.sv
// Four-way addend select: {mult bit, quotient bit} picks 0, N, B or B+N.
module msm_opnd_mux #(
  parameter int W = 34
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] b_val,
  input  logic [W-1:0] n_val,
  input  logic [W-1:0] bn_val,
  output logic [W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      2'b00:   opnd = '0;
      2'b01:   opnd = n_val;
      2'b10:   opnd = b_val;
      default: opnd = bn_val;
    endcase
  end
endmodule

// File: rtl/msm_csa_row.sv
// One level of 3:2 compression; the carry word is weighted one place up.
module msm_csa_row #(
  parameter int W = 34
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] car
);
  assign sum    = x ^ y ^ z;
  assign car[0] = 1'b0;
  for (genvar g = 0; g < W - 1; g++) begin : g_maj
    assign car[g+1] = (x[g] & y[g]) | (x[g] & z[g]) | (y[g] & z[g]);
  end
endmodule

// File: rtl/msm_final_conv.sv
// Carry-propagate join of the halved carry-save pair, then one conditional subtract.
module msm_final_conv #(
  parameter int K = 32
) (
  input  logic [K:0]   half_s,
  input  logic [K:0]   half_c,
  input  logic [K-1:0] n_val,
  output logic [K-1:0] res
);
  logic [K+1:0] total;
  logic [K-1:0] less_n;
  logic         ge_n;

  assign total  = {1'b0, half_s} + {1'b0, half_c};
  assign ge_n   = total >= {2'b00, n_val};
  assign less_n = total[K-1:0] - n_val;
  assign res    = ge_n ? less_n : total[K-1:0];
endmodule

// File: rtl/msm_montmul.sv
module msm_montmul
  import msm_pkg::*;
#(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_a,
  input  logic [K-1:0] in_b,
  input  logic [K-1:0] in_n,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [K-1:0] out_res
);
  localparam int W  = K + 2;                  // unshifted carry-save word width
  localparam int CW = $clog2(K + 1) + 1;      // iteration index width
  localparam int LW = CW + 1;                 // latency checker width
  localparam logic [CW-1:0] K_C     = CW'(K);
  localparam logic [LW-1:0] LAT_MAX = LW'(K + 1);

  msm_state_e   state;
  logic [K-1:0] a_sh, b_q, n_q, res_q;
  logic [K:0]   bn_q;
  logic [W-1:0] acc_s, acc_c;                 // registered pair, halving still pending
  logic [CW-1:0] nxt;                         // iteration whose input is acc >> 1

  // Read side: deferred halving plus optional merge of an empty iteration.
  logic          skip, a_e, q_e, zero_hit, last_merge;
  logic [W-1:0]  cs_s, cs_c, opnd, sum_w, car_w;
  logic [CW-1:0] eidx;
  logic [K-1:0]  conv_res;

  assign skip       = !a_sh[0] && !acc_s[1] && !acc_c[1];
  assign cs_s       = skip ? (acc_s >> 2) : (acc_s >> 1);
  assign cs_c       = skip ? (acc_c >> 2) : (acc_c >> 1);
  assign a_e        = skip ? a_sh[1] : a_sh[0];
  assign q_e        = cs_s[0] ^ cs_c[0] ^ (a_e & b_q[0]);
  assign eidx       = nxt + {{(CW-1){1'b0}}, skip};
  assign last_merge = (eidx == K_C);
  assign zero_hit   = (acc_s == '0) && (acc_c == '0) && (a_sh == '0);

  msm_opnd_mux #(.W(W)) u_mux (
    .sel    ({a_e, q_e}),
    .b_val  ({2'b00, b_q}),
    .n_val  ({2'b00, n_q}),
    .bn_val ({1'b0, bn_q}),
    .opnd   (opnd)
  );

  msm_csa_row #(.W(W)) u_csa (
    .x   (cs_s),
    .y   (cs_c),
    .z   (opnd),
    .sum (sum_w),
    .car (car_w)
  );

  msm_final_conv #(.K(K)) u_conv (
    .half_s (acc_s[W-1:1]),
    .half_c (acc_c[W-1:1]),
    .n_val  (n_q),
    .res    (conv_res)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign out_res   = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      a_sh  <= '0;
      b_q   <= '0;
      n_q   <= '0;
      bn_q  <= '0;
      acc_s <= '0;
      acc_c <= '0;
      nxt   <= '0;
      res_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          a_sh  <= in_a;
          b_q   <= in_b;
          n_q   <= in_n;
          bn_q  <= {1'b0, in_b} + {1'b0, in_n};
          acc_s <= '0;
          acc_c <= '0;
          nxt   <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (zero_hit) begin
            state <= ST_FIN;
          end else if (last_merge) begin
            acc_s <= cs_s << 1;
            acc_c <= cs_c << 1;
            nxt   <= K_C;
            state <= ST_FIN;
          end else begin
            acc_s <= sum_w;
            acc_c <= car_w;
            nxt   <= eidx + CW'(1);
            a_sh  <= skip ? (a_sh >> 2) : (a_sh >> 1);
            if (eidx + CW'(1) == K_C) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          res_q <= conv_res;
          state <= ST_OUT;
        end
        default: if (out_ready) state <= ST_IDLE;
      endcase
    end
  end

  // Latency checker: edges since acceptance while RUN or FIN.
  logic [LW-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (state == ST_IDLE) lat_cnt <= '0;
    else if (state != ST_OUT) lat_cnt <= lat_cnt + LW'(1);
  end

  // R1: quotient choice leaves both registered words even, so deferred halving is exact
  a_r1_lsb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> (acc_s[0] == 1'b0 && acc_c[0] == 1'b0));

  a_r2_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_res < n_q));

  a_r3_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

  a_r6_latency_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt <= LAT_MAX));
endmodule

// File: tb/tb_msm_montmul.sv
module tb_msm_montmul;
  localparam int K = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [K-1:0] in_a = '0, in_b = '0, in_n = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [K-1:0] out_res;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  msm_montmul #(.K(K)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_n(in_n), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent reference: (A*B mod N), then K modular halvings.
  function automatic logic [K-1:0] ref_mm(input logic [K-1:0] a, b, n);
    logic [2*K-1:0] x;
    x = ({{K{1'b0}}, a} * {{K{1'b0}}, b}) % {{K{1'b0}}, n};
    for (int i = 0; i < K; i++) x = x[0] ? ((x + {{K{1'b0}}, n}) >> 1) : (x >> 1);
    return x[K-1:0];
  endfunction

  // exp_lat < 0: only range check. disturb: drive other operands while busy. stall: hold out_ready low.
  task automatic run_op(input logic [K-1:0] a, b, n, input int exp_lat, input bit disturb, input bit stall);
    logic [K-1:0] exp_r, got;
    int lat;
    exp_r = ref_mm(a, b, n);
    @(negedge clk);
    in_a = a; in_b = b; in_n = n; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R3 ready while idle", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    if (disturb) begin
      in_a = ~a; in_b = '0; in_n = n ^ 32'h2; in_valid = 1'b1;
      chk(in_ready == 1'b0, "R3 ready low while busy", in_ready, 0);
    end else in_valid = 1'b0;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (out_valid || lat > 200) break;
    end
    in_valid = 1'b0;
    got = out_res;
    chk(out_valid && got == exp_r, "R1 result", got, exp_r);
    chk(got < n, "R2 reduced", got, n);
    if (exp_lat >= 0) chk(lat == exp_lat, "R5/R7/R8 exact latency", lat, exp_lat);
    chk(lat <= K + 1, "R6 latency cap", lat, K + 1);
    if (a != 0 && b != 0) chk(lat >= K / 2 + 1, "R6 latency floor", lat, K / 2 + 1);
    if (stall) begin
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        chk(out_valid && out_res == got, "R4 held under back-pressure", out_res, got);
      end
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R4 idle after take", {out_valid, in_ready}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [K-1:0] a, b, n;
    void'($urandom(32'h1234_5a5a));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 reset state", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 after release", {in_ready, out_valid}, 2);

    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'hFFFF_FFFF, K + 1, 1'b0, 1'b0);  // R5
    run_op(32'h0, 32'h1234_5677, 32'h8000_0001, 2, 1'b0, 1'b0);             // R7
    run_op(32'h1, 32'h0, 32'hC000_0003, 3, 1'b0, 1'b0);                     // R7
    run_op(32'h8000_0000, 32'h0BAD_CAFE, 32'hF00D_0001, K / 2 + 1, 1'b0, 1'b0); // R8
    run_op(32'hDEAD_BEEF, 32'h2, 32'h3, -1, 1'b1, 1'b1);                     // R3, R4
    run_op(32'h5555_5555, 32'h7FFF_FFFE, 32'h7FFF_FFFF, -1, 1'b0, 1'b1);

    for (int t = 0; t < 40; t++) begin
      n = $urandom | 32'h1;
      if (n == 32'h1) n = 32'h3;
      b = $urandom % n;
      a = $urandom;
      run_op(a, b, n, -1, (t % 7) == 0, (t % 5) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule